// File: doc/BRIEF.md
# CGMS Line Data Generator

This block produces the digital form of the copy-generation management signal carried in the vertical blanking interval of 525-line video. A control path supplies a 20-bit payload word, an odd-field enable, an even-field enable, a check-sum generate enable and the current line standard. The video timing chain supplies a field-start pulse with the field parity, a line-start pulse taken at the horizontal sync reference, and the current line number.

On line 20 of an enabled odd field, or on line 283 of an enabled even field, the block waits a fixed number of pixel clocks after the line-start pulse. It then sends 21 bit periods of equal length. The first is a reference pulse at level one, and the 20 word bits follow, lowest bit first. It raises an active flag for the whole burst and a strobe on the first clock of every bit period, so a downstream mixer can shape amplitude and place the signal on the analog output. The low six payload bits share storage with the wide-screen signalling word that the 625-line path uses. In 625-line mode this block stays silent.

The top six word bits are a CRC over the first 14 bits. The block can compute them itself or pass the register value through unchanged. All settings are sampled once per field, so a word is never changed part way through sending.

Top module: `cgms_line_gen`

## Requirements
- R1: After reset, and until a transmission starts, `cgms_active`, `cgms_level` and `cgms_strobe` are all 0.
- R2: In an odd field (`field_odd`=1 at the last field start) with the odd enable set, a line-start pulse with `line_num`=20 starts a burst. The clock cycle after the edge that samples the pulse is offset 0, and `cgms_active` first goes high at offset START_OFS.
- R3: In an even field (`field_odd`=0) with the even enable set, a line-start pulse with `line_num`=283 starts a burst with the same timing as R2.
- R4: The odd and even enables act independently. A cleared odd enable suppresses the odd-field burst, and a cleared even enable suppresses the even-field burst, whatever the other enable holds.
- R5: When `std_525`=0 at the last field start, no burst is sent on any line.
- R6: The first bit period of a burst is a reference pulse with `cgms_level`=1 lasting BIT_CLKS cycles.
- R7: After the reference pulse, word bits 0 to 19 are sent in that order, each for BIT_CLKS cycles. `cgms_active` stays high for exactly 21*BIT_CLKS cycles, and `cgms_level` is 0 whenever `cgms_active` is 0.
- R8: `cgms_strobe` is high on the first cycle of each of the 21 bit periods and low on every other cycle.
- R9: With the CRC enable set, word bits 0 to 13 are `cfg_payload[13:0]`. The CRC uses the polynomial x^6+x+1 and a register preset to 111111, and bits 0 to 13 are fed in sending order, each step being fb = bit xor reg[5], reg = (reg<<1) xor (fb ? 000011 : 0). Word bit 14+k carries reg[5-k] for k = 0 to 5.
- R10: With the CRC enable clear, word bits 14 to 19 are `cfg_payload[19:14]` unchanged.
- R11: Payload, enables, CRC enable, standard and parity are captured only on a `field_start` pulse. Changes between field starts have no effect on the bursts of the current field.
- R12: A line-start pulse on any line other than the designated line for the current parity sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| std_525 | input | 1 | 1 selects 525-line operation |
| cfg_payload | input | 20 | Payload word; bit 0 is sent first |
| cfg_odd_en | input | 1 | Send in odd fields |
| cfg_even_en | input | 1 | Send in even fields |
| cfg_crc_en | input | 1 | 1 replaces bits 19:14 with the computed CRC |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| field_odd | input | 1 | Parity of the field that is starting |
| line_start | input | 1 | One-cycle pulse at the horizontal sync reference |
| line_num | input | LINE_W | Current line number, valid with `line_start` |
| cgms_level | output | 1 | Serial signal level |
| cgms_strobe | output | 1 | First cycle of each bit period |
| cgms_active | output | 1 | Burst in progress |

## Verification
Settings become visible to the line path on the clock edge that samples `field_start`. Burst outputs are counted from the edge that samples `line_start`: the cycle after it is offset 0, the reference pulse starts at offset START_OFS, and bit n spans offsets START_OFS+(n+1)*BIT_CLKS to START_OFS+(n+2)*BIT_CLKS-1. The bench drives and samples on falling edges and steps one offset per falling edge from that point. It compares every cycle of the window, including a few cycles past the expected end, against a waveform built from the requirements.

// File: rtl/cgms_pkg.sv
package cgms_pkg;

    localparam int WORD_W = 20;
    localparam int CRC_W  = 6;
    localparam int DATA_W = WORD_W - CRC_W;
    localparam int NSLOTS = WORD_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SEND
    } phase_e;

    typedef struct packed {
        logic              std525;
        logic              odd_en;
        logic              even_en;
        logic              odd_field;
        logic [WORD_W-1:0] word;
    } shadow_t;

endpackage

// File: rtl/cgms_crc6.sv
module cgms_crc6 #(
    parameter int          DW   = 14,
    parameter int          CW   = 6,
    parameter logic [CW-1:0] POLY = 6'h03,
    parameter logic [CW-1:0] SEED = 6'h3F
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] crc
);
    logic [CW-1:0] stage [0:DW];

    assign stage[0] = SEED;

    generate
        for (genvar i = 0; i < DW; i++) begin : g_step
            logic fb;
            assign fb = data[i] ^ stage[i][CW-1];
            assign stage[i+1] = {stage[i][CW-2:0], 1'b0} ^ ({CW{fb}} & POLY);
        end
    endgenerate

    assign crc = stage[DW];
endmodule

// File: rtl/cgms_shadow.sv
module cgms_shadow
    import cgms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              std_525,
    input  logic              odd_en,
    input  logic              even_en,
    input  logic              crc_en,
    input  logic [WORD_W-1:0] payload,
    output shadow_t           sh
);
    logic [CRC_W-1:0]  crc_calc;
    logic [CRC_W-1:0]  crc_flip;
    logic [WORD_W-1:0] word_new;
    shadow_t           sh_d, sh_q;

    cgms_crc6 #(.DW(DATA_W), .CW(CRC_W)) u_crc (
        .data (payload[DATA_W-1:0]),
        .crc  (crc_calc)
    );

    // highest remainder bit goes out first after the data bits
    generate
        for (genvar k = 0; k < CRC_W; k++) begin : g_flip
            assign crc_flip[k] = crc_calc[CRC_W-1-k];
        end
    endgenerate

    assign word_new = crc_en ? {crc_flip, payload[DATA_W-1:0]} : payload;

    always_comb begin
        sh_d = sh_q;
        if (field_start) begin
            sh_d.std525    = std_525;
            sh_d.odd_en    = odd_en;
            sh_d.even_en   = even_en;
            sh_d.odd_field = field_odd;
            sh_d.word      = word_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sh = sh_q;

    // R11: settings only move on a field boundary
    assert_hold_between_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(sh_q));

endmodule

// File: rtl/cgms_serializer.sv
module cgms_serializer
    import cgms_pkg::*;
#(
    parameter int BIT_CLKS  = 30,
    parameter int START_OFS = 150,
    parameter int LINE_W    = 10,
    parameter int ODD_LINE  = 20,
    parameter int EVEN_LINE = 283
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  shadow_t           sh,
    output logic              active,
    output logic              level,
    output logic              strobe
);
    localparam int MAXC     = (BIT_CLKS > START_OFS) ? BIT_CLKS : START_OFS;
    localparam int TICK_W   = $clog2(MAXC + 1);
    localparam int SLOT_W   = $clog2(NSLOTS + 1);
    localparam int LEAD_END = (START_OFS > 0) ? START_OFS - 1 : 0;
    localparam logic [TICK_W-1:0] BIT_LAST  = TICK_W'(BIT_CLKS - 1);
    localparam logic [TICK_W-1:0] LEAD_LAST = TICK_W'(LEAD_END);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NSLOTS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [TICK_W-1:0] tick;
        logic [SLOT_W-1:0] slot;
    } ser_t;

    ser_t              st_d, st_q;
    logic              go;
    logic [SLOT_W-1:0] data_idx;

    always_comb begin
        st_d = st_q;
        go   = sh.std525 &&
               (( sh.odd_field && sh.odd_en  && line_num == LINE_W'(ODD_LINE)) ||
                (!sh.odd_field && sh.even_en && line_num == LINE_W'(EVEN_LINE)));
        case (st_q.phase)
            PH_IDLE: begin
                if (line_start && go) begin
                    st_d.tick  = '0;
                    st_d.slot  = '0;
                    st_d.phase = (START_OFS == 0) ? PH_SEND : PH_LEAD;
                end
            end
            PH_LEAD: begin
                if (st_q.tick == LEAD_LAST) begin
                    st_d.tick  = '0;
                    st_d.phase = PH_SEND;
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
            PH_SEND: begin
                if (st_q.tick == BIT_LAST) begin
                    st_d.tick = '0;
                    if (st_q.slot == SLOT_LAST) st_d.phase = PH_IDLE;
                    else                        st_d.slot  = st_q.slot + 1'b1;
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, tick: '0, slot: '0};
        else        st_q <= st_d;
    end

    assign data_idx = st_q.slot - 1'b1;
    assign active   = (st_q.phase == PH_SEND);
    assign strobe   = active && (st_q.tick == '0);
    assign level    = active && ((st_q.slot == '0) ? 1'b1 : sh.word[data_idx]);

    // R6: a burst opens with the reference pulse and a strobe
    assert_ref_pulse_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (level && strobe));

    // R7: level holds for the whole of a bit period
    assert_level_held_in_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.tick != '0) |-> $stable(level));

    // R7: the burst ends after the last word bit
    assert_burst_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.tick == BIT_LAST && st_q.slot == SLOT_LAST) |=> !active);

endmodule

// File: rtl/cgms_line_gen.sv
module cgms_line_gen
    import cgms_pkg::*;
#(
    parameter int BIT_CLKS  = 30,
    parameter int START_OFS = 150,
    parameter int LINE_W    = 10,
    parameter int ODD_LINE  = 20,
    parameter int EVEN_LINE = 283
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_525,
    input  logic [19:0]       cfg_payload,
    input  logic              cfg_odd_en,
    input  logic              cfg_even_en,
    input  logic              cfg_crc_en,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    output logic              cgms_level,
    output logic              cgms_strobe,
    output logic              cgms_active
);
    shadow_t sh;

    cgms_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .field_odd   (field_odd),
        .std_525     (std_525),
        .odd_en      (cfg_odd_en),
        .even_en     (cfg_even_en),
        .crc_en      (cfg_crc_en),
        .payload     (cfg_payload),
        .sh          (sh)
    );

    cgms_serializer #(
        .BIT_CLKS  (BIT_CLKS),
        .START_OFS (START_OFS),
        .LINE_W    (LINE_W),
        .ODD_LINE  (ODD_LINE),
        .EVEN_LINE (EVEN_LINE)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_num   (line_num),
        .sh         (sh),
        .active     (cgms_active),
        .level      (cgms_level),
        .strobe     (cgms_strobe)
    );

    // R5: a field captured in 625-line mode never opens a burst
    assert_silent_in_625_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh.std525 && !cgms_active) |=> !cgms_active);

    // R1: no level or strobe outside a burst
    assert_quiet_outside_burst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cgms_active |-> (!cgms_level && !cgms_strobe));

endmodule

// File: tb/sim_cgms_line_gen.sv
`timescale 1ns/1ps
module sim_cgms_line_gen;
    localparam int BC = 4;
    localparam int SO = 5;
    localparam int BURST = 21 * BC;
    localparam int WIN = SO + BURST + 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        std_525 = 1'b0;
    logic [19:0] cfg_payload = '0;
    logic        cfg_odd_en = 1'b0, cfg_even_en = 1'b0, cfg_crc_en = 1'b0;
    logic        field_start = 1'b0, field_odd = 1'b0, line_start = 1'b0;
    logic [9:0]  line_num = '0;
    logic        cgms_level, cgms_strobe, cgms_active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cgms_line_gen #(.BIT_CLKS(BC), .START_OFS(SO)) u0 (
        .clk(clk), .rst_n(rst_n), .std_525(std_525), .cfg_payload(cfg_payload),
        .cfg_odd_en(cfg_odd_en), .cfg_even_en(cfg_even_en), .cfg_crc_en(cfg_crc_en),
        .field_start(field_start), .field_odd(field_odd), .line_start(line_start),
        .line_num(line_num), .cgms_level(cgms_level), .cgms_strobe(cgms_strobe),
        .cgms_active(cgms_active)
    );

    typedef struct packed {
        logic        std;
        logic        oe;
        logic        ee;
        logic        ce;
        logic        fodd;
        logic [9:0]  line;
        logic [19:0] pay;
        logic        tx;
        logic [3:0]  req;
    } vec_t;

    // req numbers: R2 odd burst, R3 even burst, R4 enables, R5 625-line, R9/R10 CRC, R12 wrong line
    localparam vec_t VEC [10] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'd20,  20'hA5C3E, 1'b1, 4'd2},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd283, 20'h31234, 1'b1, 4'd3},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd20,  20'hFFFFF, 1'b0, 4'd4},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd283, 20'hFFFFF, 1'b0, 4'd4},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10'd20,  20'hFFFFF, 1'b0, 4'd5},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 10'd283, 20'hFFFFF, 1'b0, 4'd12},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd20,  20'hFFFFF, 1'b0, 4'd12},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd20,  20'hFFFFF, 1'b1, 4'd9},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd283, 20'h00001, 1'b1, 4'd10},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'd20,  20'h00000, 1'b1, 4'd9}
    };

    function automatic logic [19:0] exp_word(input logic [19:0] p, input logic ce);
        logic [5:0]  r = 6'h3F;
        logic [19:0] w = p;
        if (ce) begin
            for (int i = 0; i < 14; i++) begin
                logic fb = p[i] ^ r[5];
                r = {r[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
            end
            for (int k = 0; k < 6; k++) w[14+k] = r[5-k];
        end
        return w;
    endfunction

    task automatic new_field(input logic std, input logic oe, input logic ee, input logic ce,
                             input logic fodd, input logic [19:0] pay);
        @(negedge clk);
        std_525 = std; cfg_odd_en = oe; cfg_even_en = ee; cfg_crc_en = ce;
        cfg_payload = pay; field_odd = fodd; field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
    endtask

    // pulse line_start, then compare every cycle of the window against the expected burst
    task automatic run_line(input logic [9:0] ln, input logic tx, input logic [19:0] w, input int req);
        int bad = 0;
        int bad_k = -1;
        logic [2:0] got_b = '0, exp_b = '0;
        @(negedge clk);
        line_num = ln; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 0; k < WIN; k++) begin
            logic ea = 1'b0, el = 1'b0, es = 1'b0;
            if (tx && k >= SO && k < SO + BURST) begin
                int slot = (k - SO) / BC;
                ea = 1'b1;
                es = ((k - SO) % BC) == 0;
                el = (slot == 0) ? 1'b1 : w[slot-1];
            end
            if ({cgms_active, cgms_level, cgms_strobe} !== {ea, el, es}) begin
                if (bad == 0) begin
                    bad_k = k;
                    got_b = {cgms_active, cgms_level, cgms_strobe};
                    exp_b = {ea, el, es};
                end
                bad++;
            end
            @(negedge clk);
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R%0d line %0d offset %0d act/lvl/stb actual %b expected %b (%0d bad cycles)",
                     req, ln, bad_k, got_b, exp_b, bad);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired actual %0d cycles expected under 100000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, held in reset
        checks++;
        if ({cgms_active, cgms_level, cgms_strobe} !== 3'b000) begin
            errors++;
            $display("FAIL R1 in reset actual %b expected 000", {cgms_active, cgms_level, cgms_strobe});
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: after reset with no field captured, a line 20 pulse sends nothing
        run_line(10'd20, 1'b0, 20'h0, 1);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
        for (int v = 0; v < 10; v++) begin
            new_field(VEC[v].std, VEC[v].oe, VEC[v].ee, VEC[v].ce, VEC[v].fodd, VEC[v].pay);
            run_line(VEC[v].line, VEC[v].tx, exp_word(VEC[v].pay, VEC[v].ce), int'(VEC[v].req));
        end

        // R11: changes after the field start do not touch the captured word
        new_field(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 20'h5A5A5);
        @(negedge clk);
        cfg_payload = 20'h0F0F0; cfg_odd_en = 1'b0; cfg_crc_en = 1'b1; std_525 = 1'b0;
        run_line(10'd20, 1'b1, 20'h5A5A5, 11);

        // R11: enabling mid-field does not open a burst in that field
        new_field(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 20'h12345);
        @(negedge clk);
        cfg_odd_en = 1'b1;
        run_line(10'd20, 1'b0, 20'h0, 11);

        // R11: the next field start picks the new setting up
        new_field(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 20'h0F0F0);
        run_line(10'd20, 1'b1, exp_word(20'h0F0F0, 1'b1), 11);

        // R12: a repeated pulse on line 21 after a burst stays silent
        run_line(10'd21, 1'b0, 20'h0, 12);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule